// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This controller services one cache read miss at a time by pulling a whole 256-bit line from the next memory level, one 32-bit word per beat. It does not fetch the line from word 0 upward. It asks first for the word the processor is waiting on and then wraps around the rest of the line. As soon as that first word comes back, it is handed to the processor on a separate return path. The processor can resume while the other seven words are still on their way. Every returning beat is also written into the cache data array at its own word slot.

A valid bit is kept for each word of the line under fill rather than one bit for the whole line. A processor read that falls on the line being filled stalls only while the word it wants is still missing. Reads of words that have already landed, and reads of any other line, go through. A new miss is taken only while the controller is idle. The busy flag covers the whole fill.

The state machine has three states. `ST_IDLE` waits for a miss. `ST_FETCH` issues word requests. `ST_DRAIN` waits for outstanding beats after the last request has gone out. It has four transitions:
- *accept*: `ST_IDLE` to `ST_FETCH` on a miss handshake.
- *last issue*: `ST_FETCH` to `ST_DRAIN` when the final request is taken.
- *last beat*: `ST_DRAIN` to `ST_IDLE` when the final word returns.
- *last beat*: `ST_FETCH` to `ST_IDLE`, taken only by a memory that answers in the same cycle as the last request.

Lower memory must return beats in request order. The number of words per line must be a power of two.

Top module: `cwf_fill_ctrl`

## Requirements
- R1: After reset `busy` is 0, `miss_ready` is 1, `mem_req_valid` is 0, `restart_valid` is 0 and `sub_valid` is all zero.
- R2: The first memory request of a fill carries word address {miss line, missed word}, where the missed word is byte-address bits [4:2] of the missed byte.
- R3: Request n of a fill (n = 0..7) asks for word (k + n) mod 8, where k is the missed word. Array writes occur in the same wrapped order, with `arr_word` giving the word slot and `arr_wdata` the returned data.
- R4: `restart_valid` is high for exactly one cycle per fill. That cycle is the one in which the first beat is present on the memory response port, and `restart_data` equals that beat. With no request backpressure this is 1 + L cycles after the miss handshake, where L is the memory latency.
- R5: In the cycle after a miss is accepted, `sub_valid` is all zero. Bit i of `sub_valid` becomes 1 in the cycle after word i is written and stays 1 until the next miss is accepted.
- R6: `rd_stall` is 1 exactly when `rd_valid` is 1, `busy` is 1, `rd_line` equals the line under fill, and `sub_valid[rd_word]` is 0. It is 0 in all other cases.
- R7: `busy` is 1 from the cycle after the miss handshake until the cycle after the last beat, and `miss_ready` is its complement. A miss presented while busy has no effect on the requests issued.
- R8: A fill issues exactly 8 memory requests and exactly 8 array writes. After it, every word of the line holds the data lower memory returned for it, and all bits of `sub_valid` are 1.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid with an unchanged address in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Read miss presented |
| miss_line | input | 27 | Line address of the miss (byte address bits [31:5]) |
| miss_word | input | 3 | Missed word within the line (byte address bits [4:2]) |
| miss_ready | output | 1 | Controller can take a miss |
| busy | output | 1 | Line fill in progress |
| restart_valid | output | 1 | Critical word delivered to the processor this cycle |
| restart_data | output | 32 | Critical word data |
| mem_req_valid | output | 1 | Word request to lower memory |
| mem_req_addr | output | 30 | Word address requested |
| mem_req_ready | input | 1 | Lower memory takes the request |
| mem_rsp_valid | input | 1 | Returning beat, in request order |
| mem_rsp_data | input | 32 | Returning beat data |
| arr_we | output | 1 | Cache array word write enable |
| arr_word | output | 3 | Word slot written |
| arr_wdata | output | 32 | Word written |
| sub_valid | output | 8 | Per-word valid bits of the line under fill |
| rd_valid | input | 1 | Processor read lookup |
| rd_line | input | 27 | Line address of the read |
| rd_word | input | 3 | Word index of the read |
| rd_stall | output | 1 | Read must wait for its word |

## Verification
The assertions check the following on every cycle:
- requests follow the wrapped order from the missed word on the captured line;
- a request held off by lower memory keeps its address;
- the early restart occurs once per fill and lines up with a write of the missed word;
- the valid bits clear on acceptance and set after each write;
- all valid bits are set when busy falls;
- a stall is never raised while idle.

Only the bench scenarios can show the following:
- the exact cycle of the early restart against the memory latency;
- the data delivered to the processor and written into the array matching the memory contents;
- the stall decision for reads that hit and miss the filling line, compared against an independent valid-bit model;
- the behaviour under request backpressure;
- a back-to-back fill;
- a miss presented mid-fill being ignored.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DRAIN = 2'd2
    } fill_state_t;

endpackage

// File: rtl/cwf_wrap_idx.sv
// Wrapped word index: base plus step, modulo a power-of-two word count.
module cwf_wrap_idx #(
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] base,
    input  logic [IDX_W-1:0] step,
    output logic [IDX_W-1:0] idx
);
    always_comb idx = base + step;
endmodule

// File: rtl/cwf_valid_track.sv
// One valid flag per word of the line under fill.
module cwf_valid_track #(
    parameter int WORDS = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             set,
    input  logic [IDX_W-1:0] set_idx,
    output logic [WORDS-1:0] q
);
    for (genvar i = 0; i < WORDS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (clr)
                q[i] <= 1'b0;
            else if (set && (set_idx == IDX_W'(i)))
                q[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/cwf_fill_fsm.sv
// Sequencer: accepts a miss, issues wrapped requests, counts beats.
module cwf_fill_fsm
    import cwf_pkg::*;
#(
    parameter int LINE_ADDR_W = 27,
    parameter int IDX_W       = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   miss_valid,
    input  logic [LINE_ADDR_W-1:0] miss_line,
    input  logic [IDX_W-1:0]       miss_word,
    input  logic                   mem_req_ready,
    input  logic                   mem_rsp_valid,
    output logic                   miss_ready,
    output logic                   busy,
    output logic                   accept,
    output logic                   mem_req_valid,
    output logic                   beat,
    output logic                   first_beat,
    output logic [IDX_W-1:0]       req_step,
    output logic [IDX_W-1:0]       rsp_step,
    output logic [LINE_ADDR_W-1:0] cur_line,
    output logic [IDX_W-1:0]       crit_word
);
    localparam int WORDS = 1 << IDX_W;
    localparam logic [IDX_W:0] LAST = (IDX_W+1)'(WORDS - 1);

    fill_state_t st_q, st_nx;
    logic [IDX_W:0] req_cnt_q, rsp_cnt_q;
    logic           req_fire, last_req, last_beat;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE:  if (accept)         st_nx = ST_FETCH;
            ST_FETCH: if (last_beat)      st_nx = ST_IDLE;
                      else if (last_req)  st_nx = ST_DRAIN;
            ST_DRAIN: if (last_beat)      st_nx = ST_IDLE;
            default:                      st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        miss_ready    = (st_q == ST_IDLE);
        busy          = (st_q != ST_IDLE);
        mem_req_valid = (st_q == ST_FETCH);
        accept        = miss_valid && miss_ready;
        req_fire      = mem_req_valid && mem_req_ready;
        beat          = busy && mem_rsp_valid;
        last_req      = req_fire && (req_cnt_q == LAST);
        last_beat     = beat && (rsp_cnt_q == LAST);
        first_beat    = beat && (rsp_cnt_q == '0);
        req_step      = req_cnt_q[IDX_W-1:0];
        rsp_step      = rsp_cnt_q[IDX_W-1:0];
    end

    // fill context and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_cnt_q <= '0;
            rsp_cnt_q <= '0;
            cur_line  <= '0;
            crit_word <= '0;
        end else if (accept) begin
            req_cnt_q <= '0;
            rsp_cnt_q <= '0;
            cur_line  <= miss_line;
            crit_word <= miss_word;
        end else begin
            if (req_fire) req_cnt_q <= req_cnt_q + 1'b1;
            if (beat)     rsp_cnt_q <= rsp_cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cwf_fill_ctrl.sv
// Critical-word-first line fill controller, top level.
module cwf_fill_ctrl #(
    parameter int ADDR_W    = 32,
    parameter int LINE_BITS = 256,
    parameter int WORD_W    = 32,
    localparam int WORDS       = LINE_BITS / WORD_W,
    localparam int IDX_W       = $clog2(WORDS),
    localparam int OFF_W       = $clog2(LINE_BITS / 8),
    localparam int LINE_ADDR_W = ADDR_W - OFF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     miss_valid,
    input  logic [LINE_ADDR_W-1:0]   miss_line,
    input  logic [IDX_W-1:0]         miss_word,
    output logic                     miss_ready,
    output logic                     busy,
    output logic                     restart_valid,
    output logic [WORD_W-1:0]        restart_data,
    output logic                     mem_req_valid,
    output logic [LINE_ADDR_W+IDX_W-1:0] mem_req_addr,
    input  logic                     mem_req_ready,
    input  logic                     mem_rsp_valid,
    input  logic [WORD_W-1:0]        mem_rsp_data,
    output logic                     arr_we,
    output logic [IDX_W-1:0]         arr_word,
    output logic [WORD_W-1:0]        arr_wdata,
    output logic [WORDS-1:0]         sub_valid,
    input  logic                     rd_valid,
    input  logic [LINE_ADDR_W-1:0]   rd_line,
    input  logic [IDX_W-1:0]         rd_word,
    output logic                     rd_stall
);
    logic                   accept, beat, first_beat;
    logic [IDX_W-1:0]       req_step, rsp_step, crit_word;
    logic [IDX_W-1:0]       req_idx, rsp_idx;
    logic [LINE_ADDR_W-1:0] cur_line;

    cwf_fill_fsm #(.LINE_ADDR_W(LINE_ADDR_W), .IDX_W(IDX_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .miss_valid   (miss_valid),
        .miss_line    (miss_line),
        .miss_word    (miss_word),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .miss_ready   (miss_ready),
        .busy         (busy),
        .accept       (accept),
        .mem_req_valid(mem_req_valid),
        .beat         (beat),
        .first_beat   (first_beat),
        .req_step     (req_step),
        .rsp_step     (rsp_step),
        .cur_line     (cur_line),
        .crit_word    (crit_word)
    );

    // request-side and response-side wrapped word indices
    cwf_wrap_idx #(.IDX_W(IDX_W)) u_req_idx (
        .base(crit_word), .step(req_step), .idx(req_idx)
    );
    cwf_wrap_idx #(.IDX_W(IDX_W)) u_rsp_idx (
        .base(crit_word), .step(rsp_step), .idx(rsp_idx)
    );

    cwf_valid_track #(.WORDS(WORDS), .IDX_W(IDX_W)) u_valid (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (accept),
        .set    (beat),
        .set_idx(rsp_idx),
        .q      (sub_valid)
    );

    always_comb begin
        mem_req_addr  = {cur_line, req_idx};
        arr_we        = beat;
        arr_word      = rsp_idx;
        arr_wdata     = mem_rsp_data;
        restart_valid = first_beat;
        restart_data  = mem_rsp_data;
        rd_stall      = rd_valid && busy && (rd_line == cur_line)
                        && !sub_valid[rd_word];
    end
endmodule

// File: rtl/cwf_fill_chk.sv
// Protocol checker bound to the fill controller.
module cwf_fill_chk #(
    parameter int LINE_ADDR_W = 27,
    parameter int IDX_W       = 3,
    parameter int WORDS       = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         miss_valid,
    input logic [LINE_ADDR_W-1:0]       miss_line,
    input logic [IDX_W-1:0]             miss_word,
    input logic                         miss_ready,
    input logic                         busy,
    input logic                         restart_valid,
    input logic                         mem_req_valid,
    input logic [LINE_ADDR_W+IDX_W-1:0] mem_req_addr,
    input logic                         mem_req_ready,
    input logic                         arr_we,
    input logic [IDX_W-1:0]             arr_word,
    input logic [WORDS-1:0]             sub_valid,
    input logic                         rd_valid,
    input logic                         rd_stall
);
    logic [LINE_ADDR_W-1:0] line_q;
    logic [IDX_W-1:0]       k_q, nreq_q;
    logic                   rs_seen_q;
    logic                   fire;

    assign fire = mem_req_valid && mem_req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q    <= '0;
            k_q       <= '0;
            nreq_q    <= '0;
            rs_seen_q <= 1'b0;
        end else if (miss_valid && miss_ready) begin
            line_q    <= miss_line;
            k_q       <= miss_word;
            nreq_q    <= '0;
            rs_seen_q <= 1'b0;
        end else begin
            if (fire)          nreq_q    <= nreq_q + 1'b1;
            if (restart_valid) rs_seen_q <= 1'b1;
        end
    end

    a_r2_line_addr: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> mem_req_addr[LINE_ADDR_W+IDX_W-1:IDX_W] == line_q);

    a_r3_wrap_order: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> mem_req_addr[IDX_W-1:0] == IDX_W'(k_q + nreq_q));

    a_r4_restart_once: assert property (@(posedge clk) disable iff (!rst_n)
        restart_valid |-> !rs_seen_q);

    a_r4_restart_is_crit: assert property (@(posedge clk) disable iff (!rst_n)
        restart_valid |-> arr_we && arr_word == k_q);

    a_r5_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && miss_ready |=> sub_valid == '0);

    a_r5_set_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> sub_valid[$past(arr_word)]);

    a_r6_stall_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stall |-> busy && rd_valid);

    a_r7_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !miss_ready);

    a_r8_line_complete: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> &sub_valid);

    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
endmodule

bind cwf_fill_ctrl cwf_fill_chk #(
    .LINE_ADDR_W(LINE_ADDR_W), .IDX_W(IDX_W), .WORDS(WORDS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid   (miss_valid),
    .miss_line    (miss_line),
    .miss_word    (miss_word),
    .miss_ready   (miss_ready),
    .busy         (busy),
    .restart_valid(restart_valid),
    .mem_req_valid(mem_req_valid),
    .mem_req_addr (mem_req_addr),
    .mem_req_ready(mem_req_ready),
    .arr_we       (arr_we),
    .arr_word     (arr_word),
    .sub_valid    (sub_valid),
    .rd_valid     (rd_valid),
    .rd_stall     (rd_stall)
);

// File: tb/sim_cwf_fill_ctrl.sv
module sim_cwf_fill_ctrl;
    localparam int LW  = 27;
    localparam int IW  = 3;
    localparam int NW  = 8;
    localparam int DW  = 32;
    localparam int LAT = 4;

    typedef struct { logic [IW-1:0] idx; logic [DW-1:0] data; } wr_item_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic miss_valid = 1'b0;
    logic [LW-1:0] miss_line = '0;
    logic [IW-1:0] miss_word = '0;
    logic miss_ready, busy, restart_valid, mem_req_valid, arr_we, rd_stall;
    logic [DW-1:0] restart_data, arr_wdata;
    logic [LW+IW-1:0] mem_req_addr;
    logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic [IW-1:0] arr_word;
    logic [NW-1:0] sub_valid;
    logic rd_valid = 1'b0;
    logic [LW-1:0] rd_line = '0;
    logic [IW-1:0] rd_word = '0;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit bp_mode = 0, done = 0;
    wr_item_t exp_q[$];
    logic [LW+IW-1:0] rq_addr[$];
    int rq_due[$];
    logic [15:0] lfsr = 16'hACE1;

    // bench model state
    logic [LW-1:0] cur_line_tb = '0;
    logic [IW-1:0] crit_tb = '0;
    logic [NW-1:0] mask = '0;
    logic [DW-1:0] arr_model [NW];
    bit exp_busy = 0, pend_hold = 0;
    logic [LW+IW-1:0] pend_addr = '0;
    int req_n = 0, beat_n = 0, acc_cyc = 0;

    cwf_fill_ctrl u0 (.*);

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] mem_fn(input logic [LW+IW-1:0] a);
        return DW'(a) * 32'h9E37_79B1 + 32'h1357_2468;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // lower-memory model with fixed latency, plus read-lookup stimulus
    always @(negedge clk) begin
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_req_ready = bp_mode ? (lfsr[1:0] != 2'b00) : 1'b1;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            rq_addr.push_back(mem_req_addr);
            rq_due.push_back(cyc + LAT);
        end
        if (rq_due.size() != 0 && rq_due[0] <= cyc) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem_fn(rq_addr[0]);
            void'(rq_addr.pop_front());
            void'(rq_due.pop_front());
        end else begin
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = '0;
        end
        rd_valid = lfsr[3];
        rd_word  = lfsr[6:4];
        rd_line  = lfsr[7] ? cur_line_tb : cur_line_tb ^ LW'(1);
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        logic [NW-1:0] nmask;
        bit nbusy, exp_rs, exp_st;
        wr_item_t it;
        #1;
        if (rst_n && !done) begin
            nmask = mask;
            nbusy = exp_busy;
            chk(busy == exp_busy, "R7 busy", busy, exp_busy);
            chk(miss_ready == !exp_busy, "R7 miss_ready", miss_ready, !exp_busy);
            chk(sub_valid == mask, "R5 sub_valid", sub_valid, mask);
            if (pend_hold) begin
                chk(mem_req_valid && mem_req_addr == pend_addr, "R9 hold",
                    mem_req_addr, pend_addr);
            end
            pend_hold = mem_req_valid && !mem_req_ready;
            pend_addr = mem_req_addr;
            if (mem_req_valid && mem_req_ready) begin
                chk(mem_req_addr == {cur_line_tb, IW'(crit_tb + req_n)},
                    req_n == 0 ? "R2 first request" : "R3 wrap order",
                    mem_req_addr, {cur_line_tb, IW'(crit_tb + req_n)});
                req_n++;
                chk(req_n <= NW, "R8 request count", req_n, NW);
            end
            exp_rs = mem_rsp_valid && exp_busy && beat_n == 0;
            chk(restart_valid == exp_rs, "R4 restart strobe", restart_valid, exp_rs);
            if (exp_rs) begin
                chk(restart_data == mem_fn({cur_line_tb, crit_tb}), "R4 restart data",
                    restart_data, mem_fn({cur_line_tb, crit_tb}));
                if (!bp_mode)
                    chk(cyc == acc_cyc + LAT + 1, "R4 restart cycle", cyc, acc_cyc + LAT + 1);
            end
            exp_st = rd_valid && exp_busy && rd_line == cur_line_tb && !mask[rd_word];
            chk(rd_stall == exp_st, "R6 stall", rd_stall, exp_st);
            chk(arr_we == (mem_rsp_valid && exp_busy), "R8 write strobe", arr_we,
                mem_rsp_valid && exp_busy);
            if (arr_we) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R8 extra write", arr_word, 0);
                end else begin
                    it = exp_q.pop_front();
                    chk(arr_word == it.idx, "R3 write slot", arr_word, it.idx);
                    chk(arr_wdata == it.data, "R8 write data", arr_wdata, it.data);
                end
                arr_model[arr_word] = arr_wdata;
                nmask[arr_word] = 1'b1;
                beat_n++;
                if (beat_n == NW) nbusy = 0;
            end
            if (miss_valid && miss_ready) begin
                cur_line_tb = miss_line;
                crit_tb     = miss_word;
                req_n = 0; beat_n = 0; acc_cyc = cyc;
                nmask = '0; nbusy = 1;
            end
            mask = nmask;
            exp_busy = nbusy;
        end
    end

    // driver: pushes expected writes, then presents the miss
    task automatic do_fill(input logic [LW-1:0] line, input logic [IW-1:0] k,
                           input bit noise);
        int guard;
        for (int n = 0; n < NW; n++) begin
            wr_item_t e;
            e.idx  = IW'(k + n);
            e.data = mem_fn({line, e.idx});
            exp_q.push_back(e);
        end
        @(negedge clk);
        miss_valid = 1'b1; miss_line = line; miss_word = k;
        @(negedge clk);
        miss_valid = 1'b0;
        if (noise) begin
            // R7: a miss offered during the fill must be ignored
            for (int i = 0; i < 5; i++) begin
                miss_valid = 1'b1; miss_line = line ^ LW'(8'h5A); miss_word = IW'(k + 3);
                @(negedge clk);
            end
            miss_valid = 1'b0;
        end
        guard = 0;
        do begin
            @(negedge clk); guard++;
        end while ((busy || exp_q.size() != 0) && guard < 500);
        #1;
        chk(guard < 500, "R8 fill finished", guard, 500);
        chk(exp_q.size() == 0, "R8 all words written", exp_q.size(), 0);
        chk(req_n == NW, "R8 request total", req_n, NW);
        chk(sub_valid == '1, "R8 line valid", sub_valid, '1);
        for (int w = 0; w < NW; w++)
            chk(arr_model[w] == mem_fn({line, IW'(w)}), "R8 line content",
                arr_model[w], mem_fn({line, IW'(w)}));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(!busy, "R1 busy", busy, 0);
        chk(miss_ready, "R1 miss_ready", miss_ready, 1);
        chk(!mem_req_valid, "R1 req", mem_req_valid, 0);
        chk(!restart_valid, "R1 restart", restart_valid, 0);
        chk(sub_valid == '0, "R1 sub_valid", sub_valid, 0);
        do_fill(27'h0000123, 3'd0, 0);
        do_fill(27'h0004567, 3'd7, 0);
        do_fill(27'h0000003, 3'd3, 0);
        bp_mode = 1;
        do_fill(27'h0007ABC, 3'd5, 0);
        do_fill(27'h1FFFFFF, 3'd2, 0);
        bp_mode = 0;
        do_fill(27'h0000055, 3'd2, 1);
        do_fill(27'h0000001, 3'd6, 0);
        do_fill(27'h0000002, 3'd1, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        done = 1;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule